// File: doc/BRIEF.md
# Shadowed Pointer Indirect Access Unit

This block holds the 128-byte internal data RAM of an 8-bit microcontroller core. The lowest 32 bytes of that RAM also serve as four banks of eight working registers. These registers are not separate storage: a register access is only another way of forming a RAM address. The two pointer registers at offsets 0 and 1 of every bank are also kept in flip-flops. The unit writes each of these copies whenever the matching RAM byte is written, so an indirect operand address is available at once and the pointer never has to be read from RAM first.

The core uses an ordinary byte port to read and write the RAM and a small command port to increment or decrement the operand that a pointer selects. The operand is the byte whose address is held in the chosen pointer. The command takes three clocks: read the operand, compute the new value, write it back. While a command runs, the sequencer owns the RAM port. The current indirect address for the selected bank and pointer is always available on an output.

Top module: `iram_indirect_unit`

## Requirements
- R1: `ram_rdata` shows the byte at the `ram_addr` that was presented on the previous clock (address range 0..127). When a write and a read hit the same address on one edge, the old value is returned.
- R2: After a synchronous active-high reset, every RAM byte reads 0x00, `ind_addr` is 0, and `cmd_busy` and `cmd_done` are low.
- R3: The pointer copies at addresses 0x00, 0x01, 0x08, 0x09, 0x10, 0x11, 0x18 and 0x19 always equal their RAM bytes. This holds for writes from the byte port and for command write-backs, including a write-back to a pointer location itself.
- R4: `ind_addr` equals bits 6:0 of the byte at address `bank_sel`*8 + `ptr_sel`. It follows a change of selection without waiting for a clock, and it reflects a write from the clock edge that performs the write.
- R5: A command is accepted on an edge where `cmd_valid` is high and `cmd_busy` is low. `cmd_busy` is then high for exactly three cycles.
- R6: Busy cycle 1 reads the operand at the address taken from the pointer copy, with bank and pointer captured at acceptance. Cycle 2 computes the new value. Cycle 3 writes it back to the same address, and `cmd_done` is high in cycle 3 only. `cmd_dec`=0 increments and `cmd_dec`=1 decrements.
- R7: While `cmd_busy` is high, byte-port writes, `cmd_valid`, and changes of `bank_sel`, `ptr_sel` and `cmd_dec` have no effect on the command or on RAM contents.
- R8: The increment and decrement wrap within 8 bits: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R9: A pointer with bit 7 set addresses RAM with its low seven bits only; for example, 0xC5 selects 0x45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ram_addr | input | 7 | Byte port address |
| ram_wdata | input | 8 | Byte port write data |
| ram_we | input | 1 | Byte port write enable |
| ram_rdata | output | 8 | Read data, one clock after the address |
| bank_sel | input | 2 | Active register bank |
| ptr_sel | input | 1 | Pointer select: offset 0 or 1 |
| cmd_valid | input | 1 | Start an indirect increment or decrement |
| cmd_dec | input | 1 | 1 = decrement, 0 = increment |
| cmd_busy | output | 1 | Command in progress; byte port ignored |
| cmd_done | output | 1 | High in the write-back cycle |
| ind_addr | output | 7 | Indirect address from the selected pointer copy |

## Verification
The bench builds the unit with its default parameters: a 7-bit address, 8-bit data, four banks and two pointers per bank. With these values, pointer values with bit 7 set can reach the upper half of the byte range, so the truncation to seven address bits is exercised. They also let bank 3 hold pointers that point at its own mirrored bytes, so a write-back lands on a pointer copy. Directed commands cover wraparound in both directions and byte-port writes made during a busy command. A randomized phase mixes writes aimed at the mirrored bytes with back-to-back commands.

// File: rtl/iram_ptr_pkg.sv
`timescale 1ns/1ps
package iram_ptr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_CALC  = 2'd2,
    SEQ_WRITE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/iram_store.sv
`timescale 1ns/1ps
module iram_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // Array without reset so it maps to block RAM; read-first behaviour
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rd_q <= mem[addr];
  end

  // Per-byte written mask gives zero-after-reset without touching the array
  logic [DEPTH-1:0] written_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= written_q[addr];
      if (we) written_q[addr] <= 1'b1;
    end
  end

  assign rdata = vld_q ? rd_q : '0;

  // R2
  reset_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == '0);

endmodule

// File: rtl/iram_ptr_shadow.sv
`timescale 1ns/1ps
module iram_ptr_shadow #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int BANK_REGS = 8,
  parameter int NUM_PTRS  = 2,
  parameter int NUM_SLOTS = NUM_BANKS * NUM_PTRS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NUM_SLOTS*DATA_W-1:0] slots_flat
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
      localparam int SLOT = b * NUM_PTRS + p;
      localparam logic [ADDR_W-1:0] LOC = ADDR_W'(b * BANK_REGS + p);
      logic [DATA_W-1:0] copy_q;

      // Snoops the arbitrated write bus, so every write source is seen
      always_ff @(posedge clk) begin
        if (rst)                          copy_q <= '0;
        else if (wr_en && wr_addr == LOC) copy_q <= wr_data;
      end

      assign slots_flat[SLOT*DATA_W +: DATA_W] = copy_q;
    end
  end

endmodule

// File: rtl/iram_rmw_seq.sv
`timescale 1ns/1ps
module iram_rmw_seq
  import iram_ptr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_dec,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [BANK_W-1:0] sel_bank,
  output logic [PTR_W-1:0]  sel_ptr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              eng_we,
  output logic [DATA_W-1:0] eng_wdata
);
  seq_state_e        state_q;
  logic              dec_q;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      dec_q    <= 1'b0;
      sel_bank <= '0;
      sel_ptr  <= '0;
      res_q    <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (cmd_valid) begin
          state_q  <= SEQ_READ;
          dec_q    <= cmd_dec;
          sel_bank <= cmd_bank;
          sel_ptr  <= cmd_ptr;
        end
        SEQ_READ:  state_q <= SEQ_CALC;
        SEQ_CALC: begin
          res_q   <= dec_q ? rd_data - DATA_W'(1) : rd_data + DATA_W'(1);
          state_q <= SEQ_WRITE;
        end
        SEQ_WRITE: state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = state_q != SEQ_IDLE;
  assign done      = state_q == SEQ_WRITE;
  assign eng_we    = state_q == SEQ_WRITE;
  assign eng_addr  = ptr_addr;
  assign eng_wdata = res_q;

  // R5
  accept_starts_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  // R5
  busy_ends_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R5
  done_after_two_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && $past(busy, 2)));

  // R6
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/iram_indirect_unit.sv
`timescale 1ns/1ps
module iram_indirect_unit #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int BANK_REGS = 8,
  parameter int NUM_PTRS  = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PTR_W    = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_wdata,
  input  logic              ram_we,
  output logic [DATA_W-1:0] ram_rdata,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [PTR_W-1:0]  ptr_sel,
  input  logic              cmd_valid,
  input  logic              cmd_dec,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic [ADDR_W-1:0] ind_addr
);
  localparam int NUM_SLOTS = NUM_BANKS * NUM_PTRS;
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS*DATA_W-1:0] slots_flat;
  logic [DATA_W-1:0]           slot_val [NUM_SLOTS];

  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_we;

  logic [BANK_W-1:0] eng_bank;
  logic [PTR_W-1:0]  eng_ptr;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_wdata;
  logic              eng_we;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_unpack
    assign slot_val[s] = slots_flat[s*DATA_W +: DATA_W];
  end

  logic [SLOT_W-1:0] ext_slot, eng_slot;
  assign ext_slot = SLOT_W'(int'(bank_sel) * NUM_PTRS + int'(ptr_sel));
  assign eng_slot = SLOT_W'(int'(eng_bank) * NUM_PTRS + int'(eng_ptr));

  assign ind_addr = slot_val[ext_slot][ADDR_W-1:0];

  // Sequencer takes the whole RAM port while busy
  always_comb begin
    if (cmd_busy) begin
      mem_addr  = eng_addr;
      mem_we    = eng_we;
      mem_wdata = eng_wdata;
    end else begin
      mem_addr  = ram_addr;
      mem_we    = ram_we;
      mem_wdata = ram_wdata;
    end
  end

  iram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .we    (mem_we),
    .rdata (ram_rdata)
  );

  iram_ptr_shadow #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .BANK_REGS (BANK_REGS),
    .NUM_PTRS  (NUM_PTRS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (mem_we),
    .wr_addr    (mem_addr),
    .wr_data    (mem_wdata),
    .slots_flat (slots_flat)
  );

  iram_rmw_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .PTR_W  (PTR_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_dec   (cmd_dec),
    .cmd_bank  (bank_sel),
    .cmd_ptr   (ptr_sel),
    .ptr_addr  (slot_val[eng_slot][ADDR_W-1:0]),
    .rd_data   (ram_rdata),
    .sel_bank  (eng_bank),
    .sel_ptr   (eng_ptr),
    .busy      (cmd_busy),
    .done      (cmd_done),
    .eng_addr  (eng_addr),
    .eng_we    (eng_we),
    .eng_wdata (eng_wdata)
  );

  // Which copy, if any, mirrors the address now on the RAM port
  logic              mir_hit;
  logic [DATA_W-1:0] mir_val;
  always_comb begin
    mir_hit = 1'b0;
    mir_val = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (mem_addr == ADDR_W'((s / NUM_PTRS) * BANK_REGS + (s % NUM_PTRS))) begin
        mir_hit = 1'b1;
        mir_val = slot_val[s];
      end
    end
  end

  // R3
  shadow_matches_ram_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mir_hit)) |-> ram_rdata == $past(mir_val));

  // R6
  writeback_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_we && cmd_busy) |-> mem_addr == $past(mem_addr, 2));

endmodule

// File: tb/test_iram_indirect_unit.sv
`timescale 1ns/1ps
module test_iram_indirect_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ram_addr = '0;
  logic [7:0] ram_wdata = '0;
  logic       ram_we = 1'b0;
  logic [7:0] ram_rdata;
  logic [1:0] bank_sel = '0;
  logic       ptr_sel = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_dec = 1'b0;
  logic       cmd_busy, cmd_done;
  logic [6:0] ind_addr;

  always #(CLK_P/2) clk = ~clk;

  iram_indirect_unit i_iram_indirect_unit (
    .clk(clk), .rst(rst), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_rdata(ram_rdata), .bank_sel(bank_sel),
    .ptr_sel(ptr_sel), .cmd_valid(cmd_valid), .cmd_dec(cmd_dec),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done), .ind_addr(ind_addr)
  );

  int    nchk = 0;
  int    nfail = 0;
  string phase = "reset";
  bit    chk_on = 1'b0;

  task automatic cmp(int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", what, phase, act, exp);
    end
  endtask

  // Behavioural reference: memory image plus a busy-cycle counter
  int m_mem [128];
  int m_st, m_b, m_p, m_dec, m_rd, m_res;
  int a_i, we_i, wd_i, rd_n;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_st = 0; m_b = 0; m_p = 0; m_dec = 0; m_rd = 0; m_res = 0;
      chk_on = 1'b1;
    end else begin
      if (m_st == 0) begin
        a_i = ram_addr; we_i = ram_we; wd_i = ram_wdata;
      end else begin
        a_i = m_mem[m_b*8 + m_p] % 128; we_i = (m_st == 3); wd_i = m_res;
      end
      rd_n = m_mem[a_i];
      if (m_st == 2) m_res = m_dec ? (m_rd + 255) % 256 : (m_rd + 1) % 256;
      if (we_i != 0) m_mem[a_i] = wd_i;
      m_rd = rd_n;
      case (m_st)
        0: if (cmd_valid) begin
             m_st = 1; m_b = bank_sel; m_p = ptr_sel; m_dec = cmd_dec;
           end
        3: m_st = 0;
        default: m_st = m_st + 1;
      endcase
    end
  end

  // Per-clock comparison, half a period away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      cmp(ram_rdata, m_rd, "R1 read data");
      cmp(cmd_busy, m_st != 0, "R5 busy");
      cmp(cmd_done, m_st == 3, "R6 done");
      cmp(ind_addr, m_mem[bank_sel*8 + ptr_sel] % 128, "R4 indirect address");
    end
  end

  task automatic wr(int a, int d);
    ram_addr = 7'(a); ram_wdata = 8'(d); ram_we = 1'b1;
    @(posedge clk); #1;
    ram_we = 1'b0;
  endtask

  task automatic rd_chk(int a, int exp, string what);
    ram_addr = 7'(a); ram_we = 1'b0;
    @(posedge clk); #1;
    cmp(ram_rdata, exp, what);
  endtask

  task automatic cmd(int b, int p, int d);
    bank_sel = 2'(b); ptr_sel = 1'(p); cmd_dec = 1'(d); cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog expired [%s] actual=running expected=finished", phase);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    phase = "R2 after reset";
    for (int k = 0; k < 4; k++) begin
      bank_sel = 2'(k); ptr_sel = 1'(k % 2);
      rd_chk(k * 37, 0, "R2 zero after reset");
    end
    cmp(ind_addr, 0, "R2 indirect address after reset");

    phase = "pointer setup";
    wr(8'h00, 8'h40); wr(8'h01, 8'h41); wr(8'h08, 8'hC5);
    wr(8'h11, 8'h7F); wr(8'h18, 8'h19); wr(8'h19, 8'h18);
    wr(8'h40, 8'hFF); wr(8'h41, 8'h00); wr(8'h45, 8'h10); wr(8'h7F, 8'h80);
    bank_sel = 2'd1; ptr_sel = 1'b0; #1;
    cmp(ind_addr, 8'h45, "R9 pointer bit 7 dropped");

    phase = "directed commands";
    cmd(0, 0, 0); rd_chk(8'h40, 8'h00, "R8 increment wraps");
    cmd(0, 1, 1); rd_chk(8'h41, 8'hFF, "R8 decrement wraps");
    cmd(1, 0, 0); rd_chk(8'h45, 8'h11, "R9 truncated pointer target");
    cmd(2, 1, 1); rd_chk(8'h7F, 8'h7F, "R6 decrement result");
    cmd(3, 0, 0); rd_chk(8'h19, 8'h19, "R3 write-back into pointer byte");
    bank_sel = 2'd3; ptr_sel = 1'b1; #1;
    cmp(ind_addr, 8'h19, "R3 copy follows write-back");
    cmd(3, 1, 0); rd_chk(8'h19, 8'h1A, "R3 self-pointing write-back");

    phase = "R7 busy interference";
    wr(8'h40, 8'h33);
    bank_sel = 2'd0; ptr_sel = 1'b0; cmd_dec = 1'b0; cmd_valid = 1'b1;
    @(posedge clk); #1;
    ram_addr = 7'h40; ram_wdata = 8'h55; ram_we = 1'b1;
    bank_sel = 2'd1; cmd_dec = 1'b1;
    repeat (3) begin @(posedge clk); #1; end
    ram_we = 1'b0; cmd_valid = 1'b0;
    rd_chk(8'h40, 8'h34, "R7 port write ignored while busy");
    rd_chk(8'h45, 8'h11, "R7 selection change ignored while busy");

    phase = "back-to-back";
    bank_sel = 2'd0; ptr_sel = 1'b1; cmd_dec = 1'b0; cmd_valid = 1'b1;
    repeat (8) begin @(posedge clk); #1; end
    cmd_valid = 1'b0;
    repeat (4) begin @(posedge clk); #1; end
    rd_chk(8'h41, 8'h01, "R5 two commands back to back");

    phase = "random";
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(1, 0) == 1)
        ram_addr = 7'($urandom_range(3, 0) * 8 + $urandom_range(1, 0));
      else
        ram_addr = 7'($urandom_range(127, 0));
      ram_wdata = 8'($urandom_range(255, 0));
      ram_we    = ($urandom_range(2, 0) == 0);
      bank_sel  = 2'($urandom_range(3, 0));
      ptr_sel   = 1'($urandom_range(1, 0));
      cmd_dec   = 1'($urandom_range(1, 0));
      cmd_valid = ($urandom_range(3, 0) == 0);
      @(posedge clk); #1;
    end
    ram_we = 1'b0; cmd_valid = 1'b0;
    repeat (5) begin @(posedge clk); #1; end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule